// File: doc/BRIEF.md
# Serial Gain-Control Register Interface

This block is the digital control front end of a programmable-gain amplifier. A host drives three serial lines: a shift clock, a data line and an active-low load enable. While the load enable is low, each rising shift-clock edge moves one data bit into an 8-stage shift register. When the load enable rises, the frame held in the shift register is copied into holding registers. These registers drive a 6-bit gain code and a power-down flag. A transfer of new frame bits never disturbs the settings in effect until that rising edge arrives.

The last shift stage is driven onto a serial data output. It changes on falling shift-clock edges, so several such blocks can be chained behind one host. A derived output gives the selected gain in quarter-dB units. The amplifier gain is 10 dB plus 0.25 dB per code step. All three serial inputs are brought into a faster system clock domain through two-flop synchronizers, and their edges are detected there. The serial clock is at most 1 MHz, which leaves many system cycles per serial phase.

Top module: `gain_serial_ctrl`

## Requirements
- R1: A data bit is shifted in only on a rising shift-clock edge seen while the load enable is low. With the load enable high, the shift clock and data are ignored and the shift register keeps its contents.
- R2: A frame is 8 bits, and exactly 8 rising edges load a full frame. Order on the wire: the power-down bit first, then a reserved bit, then gain bits 5 down to 0. After 8 edges the first bit sits in the last stage.
- R3: On a rising load-enable edge, the gain code takes the last six bits shifted and the power-down flag takes the first bit of the last 8.
- R4: Shifting with the load enable low, or clocking with it high, leaves the gain code and power-down flag unchanged until the next rising load-enable edge.
- R5: A latched power-down bit of 1 drives the power-down flag high, and a latched 0 drives it low.
- R6: The quarter-dB output equals 40 plus the gain code. It spans 40 (10 dB) at code 0 to 103 (25.75 dB) at code 63.
- R7: The serial data output carries the last shift stage. It is updated on each falling shift-clock edge seen while the load enable is low, and holds otherwise.
- R8: After reset, the gain code is 31 (17.75 dB, quarter-dB output 71), the power-down flag is 0 and the serial data output is 0.
- R9: The shift register resets to all zeros, so a load-enable pulse with no shifting after reset latches code 0 with power-down off. The reserved bit has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_din_i | input | 1 | Serial data in |
| ser_le_n_i | input | 1 | Load enable: low to shift, rising edge to latch |
| ser_dout_o | output | 1 | Last shift stage, for chaining |
| gain_code_o | output | 6 | Latched gain code |
| pwr_down_o | output | 1 | Latched power-down flag |
| gain_qdb_o | output | 7 | Gain in quarter-dB units |

## Verification
The bound checker checks the following on every cycle:
- The shift register holds unless a qualified rising edge arrives, and moves by one stage when one does.
- The holding registers change only on a load-enable rise, and they then take the shift register contents.
- The serial output moves only on a qualified falling edge, and it then copies the last stage.

Only the bench scenarios can show the rest:
- The frame order on the wire and the reset values.
- That the reserved bit has no effect.
- The synchronizer latency.
- The chaining behaviour over frames longer than 8 bits.

// File: rtl/gain_serial_ctrl.sv
module gain_serial_ctrl #(
  parameter int FRAME_W     = 8,
  parameter int GAIN_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int RESET_CODE  = 31,
  parameter int QDB_OFFSET  = 40,
  localparam int QDB_W      = $clog2(QDB_OFFSET + (1 << GAIN_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_din_i,
  input  logic              ser_le_n_i,
  output logic              ser_dout_o,
  output logic [GAIN_W-1:0] gain_code_o,
  output logic              pwr_down_o,
  output logic [QDB_W-1:0]  gain_qdb_o
);

  localparam int PD_POS = FRAME_W - 1;

  logic [SYNC_STAGES-1:0] sck_sync, din_sync, le_sync;
  logic                   sck_q, le_q;
  logic                   sck_s, din_s, le_s;
  logic                   sck_rise, sck_fall, le_rise;
  logic [FRAME_W-1:0]     shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync <= '0;
      din_sync <= '0;
      le_sync  <= '1;
      sck_q    <= 1'b0;
      le_q     <= 1'b1;
    end else begin
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], ser_clk_i};
      din_sync <= {din_sync[SYNC_STAGES-2:0], ser_din_i};
      le_sync  <= {le_sync[SYNC_STAGES-2:0], ser_le_n_i};
      sck_q    <= sck_s;
      le_q     <= le_s;
    end
  end

  assign sck_s    = sck_sync[SYNC_STAGES-1];
  assign din_s    = din_sync[SYNC_STAGES-1];
  assign le_s     = le_sync[SYNC_STAGES-1];
  assign sck_rise = sck_s & ~sck_q & ~le_s;
  assign sck_fall = ~sck_s & sck_q & ~le_s;
  assign le_rise  = le_s & ~le_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shift_q <= '0;
    else if (sck_rise) shift_q <= {shift_q[FRAME_W-2:0], din_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ser_dout_o <= 1'b0;
    else if (sck_fall) ser_dout_o <= shift_q[PD_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_code_o <= GAIN_W'(RESET_CODE);
      pwr_down_o  <= 1'b0;
    end else if (le_rise) begin
      gain_code_o <= shift_q[GAIN_W-1:0];
      pwr_down_o  <= shift_q[PD_POS];
    end
  end

  assign gain_qdb_o = QDB_W'(QDB_OFFSET) + QDB_W'(gain_code_o);

endmodule

// File: rtl/gain_serial_ctrl_chk.sv
module gain_serial_ctrl_chk #(
  parameter int FRAME_W = 8,
  parameter int GAIN_W  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sck_rise,
  input logic               sck_fall,
  input logic               le_rise,
  input logic [FRAME_W-1:0] shift_q,
  input logic [GAIN_W-1:0]  gain_code_o,
  input logic               pwr_down_o,
  input logic               ser_dout_o
);

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sck_rise |=> $stable(shift_q)); // R1
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n) sck_rise |=> shift_q[FRAME_W-1:1] == $past(shift_q[FRAME_W-2:0])); // R2
  AST_LATCH_GAIN: assert property (@(posedge clk) disable iff (!rst_n) le_rise |=> gain_code_o == $past(shift_q[GAIN_W-1:0])); // R3
  AST_LATCH_PD: assert property (@(posedge clk) disable iff (!rst_n) le_rise |=> pwr_down_o == $past(shift_q[FRAME_W-1])); // R5
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n) !le_rise |=> $stable(gain_code_o) && $stable(pwr_down_o)); // R4
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sck_fall |=> $stable(ser_dout_o)); // R7
  AST_DOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n) sck_fall |=> ser_dout_o == $past(shift_q[FRAME_W-1])); // R7

endmodule

bind gain_serial_ctrl gain_serial_ctrl_chk #(.FRAME_W(FRAME_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall), .le_rise(le_rise),
  .shift_q(shift_q), .gain_code_o(gain_code_o), .pwr_down_o(pwr_down_o), .ser_dout_o(ser_dout_o)
);

// File: tb/gain_serial_ctrl_tb.sv
module gain_serial_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, din = 1'b0, le_n = 1'b1;
  logic dout, pd;
  logic [5:0] gain;
  logic [6:0] qdb;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] m_sr = '0;
  logic [5:0] m_gain = 6'd31;
  logic m_pd = 1'b0, m_dout = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_serial_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .ser_din_i(din), .ser_le_n_i(le_n),
    .ser_dout_o(dout), .gain_code_o(gain), .pwr_down_o(pd), .gain_qdb_o(qdb)
  );

  function automatic int exp_qdb(input logic [5:0] c);
    return 40 + int'(c);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    din = b;
    waitc(PH);
    sck = 1'b1;
    if (!le_n) m_sr = {m_sr[6:0], b};
    waitc(PH);
    sck = 1'b0;
    if (!le_n) m_dout = m_sr[7];
    waitc(PH);
    check("R7 dout", int'(dout), int'(m_dout));
    check("R4 gain held", int'(gain), int'(m_gain));
    check("R4 pd held", int'(pd), int'(m_pd));
  endtask

  task automatic latch_and_check(input string tag);
    le_n = 1'b1;
    waitc(2*PH);
    m_gain = m_sr[5:0];
    m_pd = m_sr[7];
    check({tag, " R3 gain"}, int'(gain), int'(m_gain));
    check({tag, " R5 pd"}, int'(pd), int'(m_pd));
    check({tag, " R6 qdb"}, int'(qdb), exp_qdb(m_gain));
  endtask

  task automatic frame(input logic p, input logic r, input logic [5:0] g, input int extra);
    logic [7:0] f;
    f = {p, r, g};
    le_n = 1'b0;
    waitc(PH);
    for (int i = 0; i < extra; i++) send_bit(1'($urandom()));
    for (int i = 7; i >= 0; i--) send_bit(f[i]);
    latch_and_check("R2 frame");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    waitc(5);
    rst_n = 1'b1;
    waitc(4);
    check("R8 reset gain", int'(gain), 31);
    check("R8 reset pd", int'(pd), 0);
    check("R8 reset qdb", int'(qdb), 71);
    check("R8 reset dout", int'(dout), 0);

    le_n = 1'b0;
    waitc(2*PH);
    latch_and_check("R9 empty after reset");
    check("R9 zero gain", int'(gain), 0);

    frame(1'b0, 1'b0, 6'd63, 0);
    check("R6 max qdb", int'(qdb), 103);
    frame(1'b1, 1'b0, 6'd5, 0);
    check("R5 pd set", int'(pd), 1);
    frame(1'b0, 1'b1, 6'd20, 0);
    check("R9 reserved no effect gain", int'(gain), 20);
    check("R9 reserved no effect pd", int'(pd), 0);
    frame(1'b0, 1'b0, 6'd0, 0);
    check("R6 min qdb", int'(qdb), 40);

    for (int i = 0; i < 8; i++) send_bit(1'b1);
    le_n = 1'b0;
    waitc(2*PH);
    latch_and_check("R1 ignored while high");
    check("R1 sr untouched", int'(gain), 0);

    frame(1'b1, 1'b1, 6'd42, 5);
    check("R2 long frame keeps last 8", int'(gain), 42);

    for (int n = 0; n < 40; n++) begin
      logic [5:0] g;
      g = 6'($urandom_range(0, 63));
      frame(1'($urandom()), 1'($urandom()), g, ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 8)) : 0);
      check("R3 random gain", int'(gain), int'(g));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule